// File: doc/BRIEF.md
# Memory Bitfield Read-Modify-Write Sequencer

This block runs one of eight bitfield operations on a field that lives in byte-addressed memory. The field holds 1 to 32 bits and may begin at any bit of any byte. A caller supplies a base byte address, an unsigned bit offset, a width code, an opcode and a source word, then pulses `start`. The sequencer works out the first byte and how many bytes the field covers. It fetches those bytes one at a time over a byte-wide request/acknowledge port and packs them into the top of a 64-bit working buffer. It then evaluates the operation.

Operations that change the field write back the same bytes in the same ascending order. The sequencer returns a 32-bit result and negative/zero flags, and it raises `done` for one cycle when the last memory transaction has been acknowledged. A memory request is a single-cycle `memReq` pulse with `memWe` giving its direction. The memory answers each request, read or write, with one cycle of `memAck`, and for a read it places the byte on `memRdata` in that cycle.

Top module: `bitfield_rmw_seq`

## Requirements
- R1: After reset `busy`, `done` and `memReq` are low, `result` is zero and both flags are low.
- R2: The first byte accessed is `baseAddr + (bitOffset >> 3)`. Exactly `((bitOffset & 7) + width + 7) >> 3` bytes (1 to 5) are read at ascending addresses. Every request is a one-cycle `memReq` pulse, and the next request is issued only after the previous `memAck`.
- R3: The field is the `width` bits that begin at bit position `bitOffset & 7` of the first byte, counting from bit 7 of each byte down to bit 0 and then on into the next byte. For opcode 0 (test), `flagN` is the first field bit and `flagZ` is high when every field bit is zero. For opcodes 0, 2, 4, 6 and 7, `result` is the original field zero-extended, with the first field bit as its most significant bit.
- R4: Opcode 1 (unsigned extract) returns the field zero-extended to 32 bits, and its flags follow R3.
- R5: Opcode 3 (signed extract) returns the field sign-extended from its first bit, and its flags follow R3.
- R6: Opcode 5 (find first one) returns `bitOffset` plus the number of zero field bits before the first one bit. It returns `bitOffset + width` when the field is all zeros.
- R7: Opcodes 2 (invert), 4 (clear) and 6 (set) change only the field bits. They write back the same bytes at the same ascending addresses, and every bit outside the field keeps its value.
- R8: Opcode 7 (insert) replaces the field with the low `width` bits of `srcData`, placing the most significant of them first. `flagN` and `flagZ` are taken from those source bits. The insert is correct when the width is 32.
- R9: Opcodes 0, 1, 3 and 5 issue no write request.
- R10: `busy` is high from the cycle after `start` is accepted until the final acknowledge. `done` is a one-cycle pulse during which `busy` is low, and the block is idle in the cycle after `done`.
- R11: A `widthCode` of 0 selects a 32-bit field. Codes 1 to 31 select that many bits.
- R12: A `start` pulse that arrives while the block is busy is ignored, and the operation in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| baseAddr | input | 32 | Base byte address |
| bitOffset | input | 32 | Unsigned bit offset from the base address |
| widthCode | input | 5 | Field width, 0 meaning 32 |
| opcode | input | 3 | Operation selector |
| srcData | input | 32 | Source bits for insert |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Register result of the last operation |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| memReq | output | 1 | One-cycle memory request |
| memWe | output | 1 | Request is a write when high |
| memAddr | output | 32 | Byte address of the request |
| memWdata | output | 8 | Write byte |
| memRdata | input | 8 | Read byte, valid with memAck |
| memAck | input | 1 | Response or write acknowledge |

## Verification
Several properties are checked on every cycle: each request lasts a single cycle, every address lies inside the span that begins at the computed first byte, read-only opcodes never raise a write, and `done` is a lone pulse that never overlaps `busy`. Only the directed scenarios can show that the data is right. This covers the bit placement across byte boundaries, sign extension, the find-first count, the exact number and order of bytes touched, the preservation of neighbouring bits in memory, and the width-32 insert. These scenarios also vary the memory latency and inject a stray `start` during an operation.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

  typedef enum logic [2:0] {
    OP_TST  = 3'd0,
    OP_EXTU = 3'd1,
    OP_CHG  = 3'd2,
    OP_EXTS = 3'd3,
    OP_CLR  = 3'd4,
    OP_FFO  = 3'd5,
    OP_SET  = 3'd6,
    OP_INS  = 3'd7
  } bfOp_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RDREQ,
    S_RDWAIT,
    S_CALC,
    S_WRREQ,
    S_WRWAIT,
    S_FIN
  } bfState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;
    logic loadByte;
    logic compute;
  } bfStrobe_t;

endpackage

// File: rtl/bfs_ctrl.sv
module bfs_ctrl
  import bfs_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] byteCount,
  input  logic             needWrite,
  input  logic             memAck,
  output bfStrobe_t        strobe,
  output logic [CNT_W-1:0] byteIdx,
  output logic             memReq,
  output logic             memWe,
  output logic             busy,
  output logic             done
);

  bfState_e state, stateNext;
  logic [CNT_W-1:0] idxNext;
  logic lastByte;

  assign lastByte = (byteIdx == byteCount - CNT_W'(1));

  always_comb begin
    stateNext = state;
    idxNext   = byteIdx;
    unique case (state)
      S_IDLE: if (start) begin
        stateNext = S_RDREQ;
        idxNext   = '0;
      end
      S_RDREQ: stateNext = S_RDWAIT;
      S_RDWAIT: if (memAck) begin
        if (lastByte) stateNext = S_CALC;
        else begin
          stateNext = S_RDREQ;
          idxNext   = byteIdx + CNT_W'(1);
        end
      end
      S_CALC: begin
        idxNext   = '0;
        stateNext = needWrite ? S_WRREQ : S_FIN;
      end
      S_WRREQ: stateNext = S_WRWAIT;
      S_WRWAIT: if (memAck) begin
        if (lastByte) stateNext = S_FIN;
        else begin
          stateNext = S_WRREQ;
          idxNext   = byteIdx + CNT_W'(1);
        end
      end
      S_FIN: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      byteIdx <= '0;
    end else begin
      state   <= stateNext;
      byteIdx <= idxNext;
    end
  end

  assign strobe.capture  = (state == S_IDLE) && start;
  assign strobe.loadByte = (state == S_RDWAIT) && memAck;
  assign strobe.compute  = (state == S_CALC);

  assign memReq = (state == S_RDREQ) || (state == S_WRREQ);
  assign memWe  = (state == S_WRREQ);
  assign busy   = (state != S_IDLE) && (state != S_FIN);
  assign done   = (state == S_FIN);

endmodule

// File: rtl/bfs_datapath.sv
module bfs_datapath
  import bfs_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 32,
  parameter int FIELD_W = 32,
  parameter int CNT_W   = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  bfStrobe_t                 strobe,
  input  logic [ADDR_W-1:0]         baseAddr,
  input  logic [OFF_W-1:0]          bitOffset,
  input  logic [$clog2(FIELD_W)-1:0] widthCode,
  input  logic [2:0]                opIn,
  input  logic [FIELD_W-1:0]        srcIn,
  input  logic [7:0]                memRdata,
  input  logic [CNT_W-1:0]          byteIdx,
  output logic [CNT_W-1:0]          byteCount,
  output logic                      needWrite,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [7:0]                memWdata,
  output logic [FIELD_W-1:0]        result,
  output logic                      flagN,
  output logic                      flagZ
);

  localparam int BUF_W = 2 * FIELD_W;
  localparam int WC_W  = $clog2(FIELD_W);
  localparam int SH_W  = $clog2(BUF_W) + 1;

  logic [ADDR_W-1:0]  spanAddr;
  logic [2:0]         subBit;
  logic [WC_W:0]      fieldW;
  bfOp_e              opReg;
  logic [FIELD_W-1:0] srcReg;
  logic [OFF_W-1:0]   offReg;
  logic [BUF_W-1:0]   bufReg;

  // byte lane handling
  logic [SH_W-1:0]  laneShift;
  logic [BUF_W-1:0] laneOut;
  logic [SH_W-1:0]  spanBits;

  assign laneShift = SH_W'(BUF_W - 8) - (SH_W'(byteIdx) << 3);
  assign laneOut   = bufReg >> laneShift;
  assign memWdata  = laneOut[7:0];
  assign memAddr   = spanAddr + ADDR_W'(byteIdx);
  assign spanBits  = SH_W'(subBit) + SH_W'(fieldW) + SH_W'(7);
  assign byteCount = CNT_W'(spanBits >> 3);
  assign needWrite = (opReg == OP_CHG) || (opReg == OP_CLR) ||
                     (opReg == OP_SET) || (opReg == OP_INS);

  // field evaluation
  logic [SH_W-1:0]    topShift, placeShift;
  logic [FIELD_W-1:0] lowOnes, topMask, view, extU, extS, ffoRes, srcLow, srcTop;
  logic [BUF_W-1:0]   viewWide, modMask, insBits, newBuf;
  logic [WC_W:0]      leadZeros;
  logic               seenOne;
  logic [FIELD_W-1:0] resNext;
  logic               nNext, zNext;

  assign topShift   = SH_W'(FIELD_W) - SH_W'(fieldW);
  assign placeShift = SH_W'(BUF_W) - SH_W'(subBit) - SH_W'(fieldW);
  assign lowOnes    = {FIELD_W{1'b1}} >> topShift;
  assign topMask    = {FIELD_W{1'b1}} << topShift;
  assign viewWide   = bufReg << subBit;
  assign view       = viewWide[BUF_W-1:FIELD_W] & topMask;
  assign extU       = view >> topShift;
  assign extS       = $signed(view) >>> topShift;
  assign srcLow     = srcReg & lowOnes;
  assign srcTop     = srcReg << topShift;
  assign modMask    = {{FIELD_W{1'b0}}, lowOnes} << placeShift;
  assign insBits    = {{FIELD_W{1'b0}}, srcLow} << placeShift;

  always_comb begin
    leadZeros = fieldW;
    seenOne   = 1'b0;
    for (int i = 0; i < FIELD_W; i++) begin
      if (!seenOne && view[FIELD_W-1-i]) begin
        leadZeros = (WC_W+1)'(i);
        seenOne   = 1'b1;
      end
    end
  end

  assign ffoRes = FIELD_W'(offReg) + FIELD_W'(leadZeros);

  always_comb begin
    newBuf  = bufReg;
    resNext = extU;
    nNext   = view[FIELD_W-1];
    zNext   = (view == '0);
    unique case (opReg)
      OP_EXTS: resNext = extS;
      OP_FFO:  resNext = ffoRes;
      OP_CHG:  newBuf  = bufReg ^ modMask;
      OP_CLR:  newBuf  = bufReg & ~modMask;
      OP_SET:  newBuf  = bufReg | modMask;
      OP_INS: begin
        newBuf = (bufReg & ~modMask) | insBits;
        nNext  = srcTop[FIELD_W-1];
        zNext  = (srcLow == '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spanAddr <= '0;
      subBit   <= '0;
      fieldW   <= (WC_W+1)'(FIELD_W);
      opReg    <= OP_TST;
      srcReg   <= '0;
      offReg   <= '0;
      bufReg   <= '0;
      result   <= '0;
      flagN    <= 1'b0;
      flagZ    <= 1'b0;
    end else begin
      if (strobe.capture) begin
        spanAddr <= baseAddr + ADDR_W'(bitOffset >> 3);
        subBit   <= bitOffset[2:0];
        fieldW   <= (widthCode == '0) ? (WC_W+1)'(FIELD_W) : {1'b0, widthCode};
        opReg    <= bfOp_e'(opIn);
        srcReg   <= srcIn;
        offReg   <= bitOffset;
        bufReg   <= '0;
      end
      if (strobe.loadByte)
        bufReg <= bufReg | (BUF_W'(memRdata) << laneShift);
      if (strobe.compute) begin
        bufReg <= newBuf;
        result <= resNext;
        flagN  <= nNext;
        flagZ  <= zNext;
      end
    end
  end

endmodule

// File: rtl/bitfield_rmw_seq.sv
module bitfield_rmw_seq
  import bfs_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 32,
  parameter int FIELD_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [ADDR_W-1:0]          baseAddr,
  input  logic [OFF_W-1:0]           bitOffset,
  input  logic [$clog2(FIELD_W)-1:0] widthCode,
  input  logic [2:0]                 opcode,
  input  logic [FIELD_W-1:0]         srcData,
  output logic                       busy,
  output logic                       done,
  output logic [FIELD_W-1:0]         result,
  output logic                       flagN,
  output logic                       flagZ,
  output logic                       memReq,
  output logic                       memWe,
  output logic [ADDR_W-1:0]          memAddr,
  output logic [7:0]                 memWdata,
  input  logic [7:0]                 memRdata,
  input  logic                       memAck
);

  localparam int MAX_BYTES = FIELD_W / 8 + 1;
  localparam int CNT_W     = $clog2(MAX_BYTES + 1);

  bfStrobe_t        strobe;
  logic [CNT_W-1:0] byteIdx, byteCount;
  logic             needWrite;

  bfs_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .byteCount(byteCount), .needWrite(needWrite), .memAck(memAck),
    .strobe(strobe), .byteIdx(byteIdx),
    .memReq(memReq), .memWe(memWe), .busy(busy), .done(done)
  );

  bfs_datapath #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .FIELD_W(FIELD_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .baseAddr(baseAddr), .bitOffset(bitOffset), .widthCode(widthCode),
    .opIn(opcode), .srcIn(srcData), .memRdata(memRdata), .byteIdx(byteIdx),
    .byteCount(byteCount), .needWrite(needWrite),
    .memAddr(memAddr), .memWdata(memWdata),
    .result(result), .flagN(flagN), .flagZ(flagZ)
  );

endmodule

// File: rtl/bfs_checker.sv
module bfs_checker #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 32,
  parameter int FIELD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] baseAddr,
  input logic [OFF_W-1:0]  bitOffset,
  input logic [2:0]        opcode
);

  localparam int MAX_BYTES = FIELD_W / 8 + 1;

  logic [ADDR_W-1:0] spanBase;
  logic [2:0]        opSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spanBase <= '0;
      opSeen   <= '0;
    end else if (start && !busy && !done) begin
      spanBase <= baseAddr + ADDR_W'(bitOffset >> 3);
      opSeen   <= opcode;
    end
  end

  // R2: a request lasts one cycle
  a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R2: every address falls in the span of the accepted operation
  a_r2_addr_span: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> ((memAddr - spanBase) < ADDR_W'(MAX_BYTES)));

  // R9: read-only opcodes never write
  a_r9_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> !(opSeen == 3'd0 || opSeen == 3'd1 ||
                            opSeen == 3'd3 || opSeen == 3'd5));

  // R10: done is a single pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: done never overlaps busy
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R10: memory traffic only while busy
  a_r10_req_busy: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

endmodule

bind bitfield_rmw_seq bfs_checker #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .FIELD_W(FIELD_W)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
  .baseAddr(baseAddr), .bitOffset(bitOffset), .opcode(opcode)
);

// File: tb/bitfield_rmw_seq_tb.sv
module bitfield_rmw_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] baseAddr = '0;
  logic [31:0] bitOffset = '0;
  logic [4:0]  widthCode = '0;
  logic [2:0]  opcode = '0;
  logic [31:0] srcData = '0;
  logic        busy, done, flagN, flagZ, memReq, memWe;
  logic [31:0] result, memAddr;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata = '0;
  logic        memAck = 1'b0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bitfield_rmw_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .bitOffset(bitOffset), .widthCode(widthCode), .opcode(opcode),
    .srcData(srcData), .busy(busy), .done(done), .result(result),
    .flagN(flagN), .flagZ(flagZ), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memAck(memAck)
  );

  function automatic logic [7:0] patByte(input int a, input int seed);
    if (seed == 0) return 8'h00;
    if (seed == 1) return 8'hFF;
    return 8'((a * 37 + seed * 91 + 13) ^ (a >> 2));
  endfunction

  // memory model
  logic [7:0] mem [0:255];
  logic       fillEn = 1'b0;
  int         fillSeed = 2;
  logic       clrLog = 1'b0;
  int         latSel = 0;
  logic       pend = 1'b0;
  int         lat = 0;
  logic [7:0] pAddr = '0;
  int         rdCnt = 0;
  int         wrCnt = 0;
  logic [7:0] rdLog [0:7];
  logic [7:0] wrLog [0:7];

  always @(posedge clk) begin
    memAck <= 1'b0;
    if (fillEn)
      for (int i = 0; i < 256; i++) mem[i] <= patByte(i, fillSeed);
    if (clrLog) begin
      rdCnt <= 0;
      wrCnt <= 0;
    end
    if (pend) begin
      if (lat == 0) begin
        memAck   <= 1'b1;
        memRdata <= mem[pAddr];
        pend     <= 1'b0;
      end else lat <= lat - 1;
    end
    if (memReq) begin
      pend  <= 1'b1;
      pAddr <= memAddr[7:0];
      lat   <= latSel;
      if (memWe) begin
        mem[memAddr[7:0]] <= memWdata;
        if (wrCnt < 8) wrLog[wrCnt[2:0]] <= memAddr[7:0];
        wrCnt <= wrCnt + 1;
      end else begin
        if (rdCnt < 8) rdLog[rdCnt[2:0]] <= memAddr[7:0];
        rdCnt <= rdCnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected values
  logic [7:0]  expMem [0:255];
  logic [31:0] expRes;
  logic        expN, expZ;
  int          expCnt, expWr;

  task automatic model(input int base, input int off, input int w, input int op,
                       input logic [31:0] src, input int seed);
    logic [31:0] fv = '0;
    int ffo = w;
    bit found = 0;
    for (int a = 0; a < 256; a++) expMem[a] = patByte(a, seed);
    for (int i = 0; i < w; i++) begin
      int p = off + i;
      int a = (base + p / 8) & 255;
      int bp = 7 - (p % 8);
      logic [7:0] b = expMem[a];
      logic bitv = b[bp];
      fv = {fv[30:0], bitv};
      if (bitv && !found) begin ffo = i; found = 1; end
    end
    for (int i = 0; i < w; i++) begin
      int p = off + i;
      int a = (base + p / 8) & 255;
      int bp = 7 - (p % 8);
      case (op)
        2: expMem[a][bp] = ~expMem[a][bp];
        4: expMem[a][bp] = 1'b0;
        6: expMem[a][bp] = 1'b1;
        7: expMem[a][bp] = src[w-1-i];
        default: ;
      endcase
    end
    expCnt = ((off % 8) + w + 7) / 8;
    expWr  = (op == 2 || op == 4 || op == 6 || op == 7) ? expCnt : 0;
    expN   = fv[w-1];
    expZ   = (fv == 0);
    expRes = fv;
    if (op == 3 && fv[w-1] && w < 32) expRes = fv | (32'hFFFF_FFFF << w);
    if (op == 5) expRes = 32'(off + ffo);
    if (op == 7) begin
      logic [31:0] sl = (w == 32) ? src : (src & ((32'd1 << w) - 1));
      expN = src[w-1];
      expZ = (sl == 0);
    end
  endtask

  task automatic runOp(input string tag, input int base, input int off,
                       input logic [4:0] wcode, input int op,
                       input logic [31:0] src, input int seed,
                       input int latency, input bit poke);
    int w = (wcode == 0) ? 32 : int'(wcode);
    int first = (base + off / 8) & 255;
    int cnt = 0;
    int bad = -1;
    @(negedge clk);
    fillSeed = seed;
    fillEn = 1'b1;
    clrLog = 1'b1;
    latSel = latency;
    @(negedge clk);
    fillEn = 1'b0;
    clrLog = 1'b0;
    model(base, off, w, op, src, seed);
    baseAddr  = 32'hA000_0000 | 32'(base);
    bitOffset = 32'(off);
    widthCode = wcode;
    opcode    = 3'(op);
    srcData   = src;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R10", {tag, " busy after start"}, 32'(busy), 1);
    if (poke) begin
      @(negedge clk);
      baseAddr  = baseAddr + 32'd3;
      opcode    = ~opcode;
      srcData   = ~srcData;
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done !== 1'b1 && cnt < 2000) begin
      @(negedge clk);
      cnt++;
    end
    check(done === 1'b1, "R10", {tag, " done reached"}, 32'(cnt), 0);
    check(busy === 1'b0, "R10", {tag, " busy low with done"}, 32'(busy), 0);
    check(result === expRes, tag, {tag, " result"}, result, expRes);
    check(flagN === expN && flagZ === expZ, tag, {tag, " flags N,Z"},
          {30'd0, flagN, flagZ}, {30'd0, expN, expZ});
    check(rdCnt == expCnt, "R2", {tag, " read count"}, 32'(rdCnt), 32'(expCnt));
    for (int k = 0; k < expCnt && k < 8; k++)
      if (rdLog[k] !== 8'(first + k) && bad < 0) bad = k;
    check(bad < 0, "R2", {tag, " read addresses ascending"}, 32'(bad), 32'hFFFF_FFFF);
    check(wrCnt == expWr, expWr == 0 ? "R9" : "R7", {tag, " write count"},
          32'(wrCnt), 32'(expWr));
    bad = -1;
    for (int k = 0; k < expWr && k < 8; k++)
      if (wrLog[k] !== 8'(first + k) && bad < 0) bad = k;
    check(bad < 0, "R7", {tag, " write addresses"}, 32'(bad), 32'hFFFF_FFFF);
    bad = -1;
    for (int a = 0; a < 256; a++)
      if (mem[a] !== expMem[a] && bad < 0) bad = a;
    check(bad < 0, tag, {tag, " memory image"},
          bad < 0 ? 32'd0 : 32'(mem[bad]), bad < 0 ? 32'd0 : 32'(expMem[bad]));
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R10", {tag, " idle after done"},
          {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy === 0 && done === 0 && memReq === 0, "R1", "control idle",
          {29'd0, busy, done, memReq}, 0);
    check(result === 0 && flagN === 0 && flagZ === 0, "R1", "result and flags",
          result | {30'd0, flagN, flagZ}, 0);
    rstN = 1'b1;
    // R3: aligned byte test, then a test crossing bytes
    runOp("R3", 16, 0, 5'd8, 0, 0, 2, 0, 0);
    runOp("R3", 40, 21, 5'd13, 0, 0, 3, 1, 0);
    // R4: unsigned extract across three bytes
    runOp("R4", 8, 13, 5'd12, 1, 0, 4, 0, 0);
    // R5: signed extract of all-ones field and a mixed field
    runOp("R5", 20, 5, 5'd7, 3, 0, 1, 0, 0);
    runOp("R5", 30, 35, 5'd19, 3, 0, 5, 2, 0);
    // R6: find first one, hit and all-zero field
    runOp("R6", 12, 3, 5'd20, 5, 0, 6, 0, 0);
    runOp("R6", 50, 10, 5'd9, 5, 0, 0, 1, 0);
    // R7: invert, clear and set; R11: width code 0 over five bytes
    runOp("R7", 60, 6, 5'd0, 2, 0, 7, 0, 0);
    runOp("R7", 70, 0, 5'd1, 4, 0, 1, 1, 0);
    runOp("R11", 80, 7, 5'd0, 6, 0, 8, 0, 0);
    // R8: insert with width 32 and a zero source
    runOp("R8", 90, 7, 5'd0, 7, 32'h9ABC_DEF1, 9, 0, 0);
    runOp("R8", 100, 2, 5'd5, 7, 32'hFFFF_FFE0, 10, 2, 0);
    // R9: test op with latency leaves memory untouched (checked by write count)
    runOp("R9", 110, 44, 5'd31, 0, 0, 11, 2, 0);
    // R12: a start pulse during an operation is ignored
    runOp("R12", 120, 12, 5'd16, 2, 0, 12, 2, 1);
    runOp("R12", 130, 3, 5'd11, 1, 0, 13, 1, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule